// File: doc/BRIEF.md
# Rotation-based cosine window multiplier

This block multiplies a block of 512 signed samples by one full period of a cosine. The cosine is not read from a table. A two-element state vector (A, B) is stepped around the unit circle by the angle pi/256 each time a sample is accepted, and B gives the cosine value for the current sample index. The only storage is the two state registers and two fixed rotation coefficients. The price is that rounding error in the state builds up over the block. The state keeps extra fractional guard bits to slow that build-up.

A start pulse opens a block. The pulse returns the state to A = 0, B = 1 and clears the sample index. The block then accepts at most one sample per cycle on a valid strobe. Each result comes out two cycles after its sample, on its own valid strobe. The last result of the block carries a one-cycle done flag. After 512 samples, input is ignored until the next start.

Top module: `cosine_window_mul`

## Requirements
- R1: After reset, out_valid_o and done_o are low and out_data_o is 0. Samples presented before the first start pulse produce no output.
- R2: start_i sets A to 0, B to 1.0 and the sample index to 0. A sample presented in the start cycle is ignored. A start in the middle of a block restarts it, so the next sample is multiplied by exactly 1.0.
- R3: For sample index i (0 to 511), the result equals x·B_i rounded and saturated. B_i comes from the recursion A' = A·c − B·s and B' = A·s + B·c, computed from the old A and B, with c = 4193988 and s = 51471 in Q2.22. The result stays within 16 LSB of x·cos(pi·i/256), and its RMS error over a block is below 2^-10 of full scale.
- R4: Samples are Q1.15. The product is narrowed by round to nearest, with a tie rounding up. At index 1, input 32767 gives 32765.
- R5: Results are saturated to the range −32768 to 32767. Input −32768 at index 256, where B is about −1, gives a positive result of at least 32752.
- R6: out_valid_o rises exactly two cycles after an accepted sample. Idle cycles between samples do not advance the sample index.
- R7: done_o is high for exactly one cycle per block, in the same cycle as the valid of the 512th result.
- R8: After the 512th sample, samples produce no output until the next start pulse.
- R9: At index 0, the result equals the input exactly. Input 12345 gives 12345, and input −32768 gives −32768.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | One-cycle pulse that opens a new block |
| in_valid_i | input | 1 | Input sample strobe |
| in_data_i | input | 16 | Input sample, signed Q1.15 |
| out_valid_o | output | 1 | Result strobe |
| out_data_o | output | 16 | Windowed result, signed Q1.15 |
| done_o | output | 1 | Marks the last result of a block |

## Verification
- A constant half-scale input shows the shape of the generated cosine directly. It is compared over all 512 indices against a double-precision cosine.
- A constant most-negative input drives the product past full scale near index 256. It separates saturation from wrap-around.
- A pseudo-random input pattern uncovers errors that depend on the data. The same pattern is fed with idle gaps, which shows that the index advances only on accepted samples.
- Exact values at indices 0 and 1, and a restart partway through a block, pin down the rounding mode, the initial state and the reset of the state.

// File: rtl/cwm_pkg.sv
package cwm_pkg;
  // Tag travelling alongside a sample through the multiply pipeline.
  typedef struct packed {
    logic vld;
    logic last;
  } cwm_tag_t;

  localparam cwm_tag_t CWM_TAG_IDLE = '{vld: 1'b0, last: 1'b0};
endpackage

// File: rtl/cwm_round_sat.sv
// Combinational narrowing: round to nearest (tie up), then clip to OUT_W.
module cwm_round_sat #(
  parameter int IN_W  = 40,
  parameter int SHIFT = 22,
  parameter int OUT_W = 16
) (
  input  logic signed [IN_W-1:0]  din,
  output logic signed [OUT_W-1:0] dout
);
  localparam int EXT_W = IN_W + 1;
  localparam logic signed [EXT_W-1:0] HALF =
    {{(EXT_W-SHIFT){1'b0}}, 1'b1, {(SHIFT-1){1'b0}}};
  localparam logic signed [EXT_W-1:0] MAXV =
    {{(EXT_W-OUT_W+1){1'b0}}, {(OUT_W-1){1'b1}}};
  localparam logic signed [EXT_W-1:0] MINV =
    {{(EXT_W-OUT_W+1){1'b1}}, {(OUT_W-1){1'b0}}};

  logic signed [EXT_W-1:0] din_ext;
  logic signed [EXT_W-1:0] rnd;

  always_comb begin
    din_ext = {din[IN_W-1], din};
    rnd     = (din_ext + HALF) >>> SHIFT;
    if (rnd > MAXV) begin
      dout = MAXV[OUT_W-1:0];
    end else if (rnd < MINV) begin
      dout = MINV[OUT_W-1:0];
    end else begin
      dout = rnd[OUT_W-1:0];
    end
  end
endmodule

// File: rtl/cwm_seq.sv
// Block sequencer: sample index, open/closed state, acceptance.
module cwm_seq #(
  parameter int BLOCK_LEN = 512
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic in_valid_i,
  output logic accept_o,
  output logic last_o
);
  localparam int CNT_W = (BLOCK_LEN > 1) ? $clog2(BLOCK_LEN) : 1;
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(BLOCK_LEN - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             open_q, open_d;
  logic             cnt_en, open_en;

  always_comb begin
    accept_o = open_q & in_valid_i & ~start_i;
    last_o   = accept_o & (cnt_q == LAST_IDX);
    cnt_en   = start_i | accept_o;
    open_en  = start_i | last_o;
    cnt_d    = cnt_q;
    open_d   = open_q;
    if (start_i) begin
      cnt_d  = '0;
      open_d = 1'b1;
    end else if (accept_o) begin
      if (last_o) begin
        cnt_d  = '0;
        open_d = 1'b0;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      open_q <= 1'b0;
    end else begin
      if (cnt_en)  cnt_q  <= cnt_d;
      if (open_en) open_q <= open_d;
    end
  end
endmodule

// File: rtl/cwm_rotator.sv
// Recursive vector rotation producing the cosine sequence in B.
module cwm_rotator #(
  parameter int STATE_W    = 24,
  parameter int STATE_FRAC = 22,
  parameter logic signed [STATE_W-1:0] ROT_COS = 4193988,
  parameter logic signed [STATE_W-1:0] ROT_SIN = 51471
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      load_i,
  input  logic                      step_i,
  output logic signed [STATE_W-1:0] a_o,
  output logic signed [STATE_W-1:0] b_o
);
  localparam int PW = 2 * STATE_W;
  localparam int SW = PW + 1;
  localparam logic signed [STATE_W-1:0] ONE =
    {{(STATE_W-STATE_FRAC-1){1'b0}}, 1'b1, {STATE_FRAC{1'b0}}};

  logic signed [STATE_W-1:0] a_q, b_q, a_d, b_d, a_rot, b_rot;
  logic signed [PW-1:0]      p_ac, p_bs, p_as, p_bc;
  logic signed [SW-1:0]      sum_a, sum_b;
  logic                      st_en;

  always_comb begin
    p_ac  = a_q * ROT_COS;
    p_bs  = b_q * ROT_SIN;
    p_as  = a_q * ROT_SIN;
    p_bc  = b_q * ROT_COS;
    sum_a = {p_ac[PW-1], p_ac} - {p_bs[PW-1], p_bs};
    sum_b = {p_as[PW-1], p_as} + {p_bc[PW-1], p_bc};
  end

  cwm_round_sat #(.IN_W(SW), .SHIFT(STATE_FRAC), .OUT_W(STATE_W)) u_rnd_a (
    .din  (sum_a),
    .dout (a_rot)
  );

  cwm_round_sat #(.IN_W(SW), .SHIFT(STATE_FRAC), .OUT_W(STATE_W)) u_rnd_b (
    .din  (sum_b),
    .dout (b_rot)
  );

  always_comb begin
    st_en = load_i | step_i;
    if (load_i) begin
      a_d = '0;
      b_d = ONE;
    end else begin
      a_d = a_rot;
      b_d = b_rot;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_q <= '0;
      b_q <= ONE;
    end else if (st_en) begin
      a_q <= a_d;
      b_q <= b_d;
    end
  end

  assign a_o = a_q;
  assign b_o = b_q;
endmodule

// File: rtl/cwm_scaler.sv
// Two-stage multiply: register product, then round/saturate into output.
module cwm_scaler
  import cwm_pkg::*;
#(
  parameter int SAMPLE_W   = 16,
  parameter int STATE_W    = 24,
  parameter int STATE_FRAC = 22
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       accept_i,
  input  logic                       last_i,
  input  logic signed [SAMPLE_W-1:0] sample_i,
  input  logic signed [STATE_W-1:0]  gain_i,
  output logic                       out_valid_o,
  output logic signed [SAMPLE_W-1:0] out_data_o,
  output logic                       done_o
);
  localparam int PROD_W = SAMPLE_W + STATE_W;

  cwm_tag_t                   tag1_q, tag1_d, tag2_q, tag2_d;
  logic signed [PROD_W-1:0]   prod_q, prod_d;
  logic signed [SAMPLE_W-1:0] res_q, res_d;
  logic                       p1_en, p2_en;

  always_comb begin
    tag1_d = '{vld: accept_i, last: last_i};
    prod_d = sample_i * gain_i;
    p1_en  = accept_i;
    tag2_d = tag1_q;
    p2_en  = tag1_q.vld;
  end

  cwm_round_sat #(.IN_W(PROD_W), .SHIFT(STATE_FRAC), .OUT_W(SAMPLE_W)) u_rnd (
    .din  (prod_q),
    .dout (res_d)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tag1_q <= CWM_TAG_IDLE;
      tag2_q <= CWM_TAG_IDLE;
      prod_q <= '0;
      res_q  <= '0;
    end else begin
      tag1_q <= tag1_d;
      tag2_q <= tag2_d;
      if (p1_en) prod_q <= prod_d;
      if (p2_en) res_q  <= res_d;
    end
  end

  assign out_valid_o = tag2_q.vld;
  assign out_data_o  = res_q;
  assign done_o      = tag2_q.vld & tag2_q.last;
endmodule

// File: rtl/cosine_window_mul.sv
module cosine_window_mul #(
  parameter int SAMPLE_W   = 16,
  parameter int STATE_W    = 24,
  parameter int STATE_FRAC = 22,
  parameter int BLOCK_LEN  = 512,
  parameter logic signed [STATE_W-1:0] ROT_COS = 4193988,
  parameter logic signed [STATE_W-1:0] ROT_SIN = 51471
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start_i,
  input  logic                in_valid_i,
  input  logic [SAMPLE_W-1:0] in_data_i,
  output logic                out_valid_o,
  output logic [SAMPLE_W-1:0] out_data_o,
  output logic                done_o
);
  logic                      accept;
  logic                      last;
  logic signed [STATE_W-1:0] a_state, b_state;
  logic signed [SAMPLE_W-1:0] res;

  cwm_seq #(.BLOCK_LEN(BLOCK_LEN)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_i),
    .in_valid_i (in_valid_i),
    .accept_o   (accept),
    .last_o     (last)
  );

  cwm_rotator #(
    .STATE_W    (STATE_W),
    .STATE_FRAC (STATE_FRAC),
    .ROT_COS    (ROT_COS),
    .ROT_SIN    (ROT_SIN)
  ) u_rot (
    .clk    (clk),
    .rst_n  (rst_n),
    .load_i (start_i),
    .step_i (accept),
    .a_o    (a_state),
    .b_o    (b_state)
  );

  cwm_scaler #(
    .SAMPLE_W   (SAMPLE_W),
    .STATE_W    (STATE_W),
    .STATE_FRAC (STATE_FRAC)
  ) u_scl (
    .clk         (clk),
    .rst_n       (rst_n),
    .accept_i    (accept),
    .last_i      (last),
    .sample_i    ($signed(in_data_i)),
    .gain_i      (b_state),
    .out_valid_o (out_valid_o),
    .out_data_o  (res),
    .done_o      (done_o)
  );

  assign out_data_o = res;
endmodule

// File: rtl/cosine_window_mul_chk.sv
module cosine_window_mul_chk #(
  parameter int STATE_W    = 24,
  parameter int STATE_FRAC = 22
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      start_i,
  input logic                      accept,
  input logic                      out_valid_o,
  input logic                      done_o,
  input logic signed [STATE_W-1:0] a_state,
  input logic signed [STATE_W-1:0] b_state
);
  localparam logic signed [STATE_W-1:0] ONE =
    {{(STATE_W-STATE_FRAC-1){1'b0}}, 1'b1, {STATE_FRAC{1'b0}}};
  localparam logic signed [STATE_W-1:0] BMAX = ONE + (ONE >>> 6);

  // R6
  latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid_o == $past(accept, 2));

  // R7
  done_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> out_valid_o);

  // R8
  done_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !out_valid_o);

  // R2
  restart_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> (a_state == '0 && b_state == ONE));

  // R3
  amplitude_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (b_state <= BMAX) && (b_state >= -BMAX));
endmodule

bind cosine_window_mul cosine_window_mul_chk #(
  .STATE_W    (STATE_W),
  .STATE_FRAC (STATE_FRAC)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .start_i     (start_i),
  .accept      (accept),
  .out_valid_o (out_valid_o),
  .done_o      (done_o),
  .a_state     (a_state),
  .b_state     (b_state)
);

// File: tb/cosine_window_mul_test.sv
`timescale 1ns/1ps
module cosine_window_mul_test;
  localparam int N = 512;

  logic        clk;
  logic        rst_n;
  logic        start_i;
  logic        in_valid_i;
  logic [15:0] in_data_i;
  logic        out_valid_o;
  logic [15:0] out_data_o;
  logic        done_o;

  int checks;
  int fails;
  bit finished;

  int got [0:1023];
  int n_got;
  int done_cnt;
  int done_at;

  cosine_window_mul uut (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .in_valid_i  (in_valid_i),
    .in_data_i   (in_data_i),
    .out_valid_o (out_valid_o),
    .out_data_o  (out_data_o),
    .done_o      (done_o)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  always @(negedge clk) begin
    if (rst_n && done_o) begin
      done_cnt = done_cnt + 1;
      done_at  = n_got;
    end
    if (rst_n && out_valid_o) begin
      if (n_got < 1024) got[n_got] = int'($signed(out_data_o));
      n_got = n_got + 1;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks = checks + 1;
    if (!ok) begin
      fails = fails + 1;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic clear_mon();
    n_got = 0;
    done_cnt = 0;
    done_at = -1;
  endtask

  task automatic pulse_start();
    @(posedge clk); #1;
    start_i = 1'b1;
    @(posedge clk); #1;
    start_i = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  function automatic int pat(input int kind, input int i);
    case (kind)
      0: return 16384;
      1: return -32768;
      default: return ((i * 2731 + 977) % 65536) - 32768;
    endcase
  endfunction

  function automatic real ref_val(input int x, input int i);
    real r;
    r = real'(x) * $cos(3.14159265358979323846 * real'(i) / 256.0);
    if (r > 32767.0) r = 32767.0;
    if (r < -32768.0) r = -32768.0;
    return r;
  endfunction

  task automatic t_reset();
    @(negedge clk);
    check(out_valid_o == 1'b0, "R1 out_valid after reset", int'(out_valid_o), 0);
    check(done_o == 1'b0, "R1 done after reset", int'(done_o), 0);
    check(out_data_o == 16'd0, "R1 data after reset", int'(out_data_o), 0);
    clear_mon();
    for (int k = 0; k < 6; k++) begin
      @(posedge clk); #1;
      in_valid_i = 1'b1;
      in_data_i  = 16'd1000;
    end
    @(posedge clk); #1;
    in_valid_i = 1'b0;
    idle(4);
    check(n_got == 0, "R1 no output before first start", n_got, 0);
  endtask

  task automatic t_first_values();
    clear_mon();
    pulse_start();
    in_valid_i = 1'b1;
    in_data_i  = 16'd12345;
    @(posedge clk); #1;
    in_valid_i = 1'b1;
    in_data_i  = 16'd32767;
    @(negedge clk);
    check(out_valid_o == 1'b0, "R6 no output one cycle after sample", int'(out_valid_o), 0);
    @(posedge clk); #1;
    in_valid_i = 1'b0;
    @(negedge clk);
    check(out_valid_o == 1'b1, "R6 output two cycles after sample", int'(out_valid_o), 1);
    check($signed(out_data_o) == 12345, "R9 index 0 exact", int'($signed(out_data_o)), 12345);
    @(negedge clk);
    check($signed(out_data_o) == 32765, "R4 round to nearest at index 1",
          int'($signed(out_data_o)), 32765);
    idle(3);
  endtask

  task automatic t_restart();
    clear_mon();
    pulse_start();
    for (int i = 0; i < 100; i++) begin
      in_valid_i = 1'b1;
      in_data_i  = 16'(pat(2, i));
      @(posedge clk); #1;
    end
    in_valid_i = 1'b1;
    in_data_i  = 16'd7777;
    start_i    = 1'b1;
    @(posedge clk); #1;
    start_i    = 1'b0;
    in_data_i  = 16'h8000;
    @(posedge clk); #1;
    in_valid_i = 1'b0;
    idle(4);
    check(n_got == 101, "R2 start-cycle sample ignored", n_got, 101);
    check(got[100] == -32768, "R2 restart gives gain 1.0", got[100], -32768);
    check(done_cnt == 0, "R7 no done on aborted block", done_cnt, 0);
  endtask

  task automatic t_block(input int kind, input int gap, input string name);
    real se, e, emax;
    clear_mon();
    pulse_start();
    for (int i = 0; i < N; i++) begin
      in_valid_i = 1'b1;
      in_data_i  = 16'(pat(kind, i));
      @(posedge clk); #1;
      if (gap != 0) begin
        in_valid_i = 1'b0;
        repeat (gap) @(posedge clk);
        #1;
      end
    end
    in_valid_i = 1'b0;
    idle(4);
    check(n_got == N, {"R3 result count ", name}, n_got, N);
    check(done_cnt == 1 && done_at == N - 1, {"R7 single done on last result ", name},
          done_at, N - 1);
    se = 0.0;
    emax = 0.0;
    for (int i = 0; i < N; i++) begin
      e = real'(got[i]) - ref_val(pat(kind, i), i);
      if (e < 0.0) e = -e;
      if (e > emax) emax = e;
      se = se + e * e;
    end
    check(emax <= 16.0, {"R3 max error LSB ", name}, int'(emax), 16);
    check($sqrt(se / real'(N)) < 32.0, {"R3 rms error LSB ", name},
          int'($sqrt(se / real'(N))), 32);
    if (gap != 0) begin
      check(emax <= 16.0, {"R6 idle gaps keep index ", name}, int'(emax), 16);
    end
    if (kind == 1) begin
      check(got[0] == -32768, "R9 index 0 most negative", got[0], -32768);
      check(got[256] >= 32752, "R5 saturation near index 256", got[256], 32767);
    end
  endtask

  task automatic t_after_done();
    clear_mon();
    for (int k = 0; k < 8; k++) begin
      in_valid_i = 1'b1;
      in_data_i  = 16'd2222;
      @(posedge clk); #1;
    end
    in_valid_i = 1'b0;
    idle(4);
    check(n_got == 0, "R8 input ignored after block end", n_got, 0);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks = checks + 1;
    fails  = fails + 1;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    finish_run();
  end

  initial begin
    checks = 0;
    fails = 0;
    finished = 1'b0;
    clear_mon();
    rst_n = 1'b0;
    start_i = 1'b0;
    in_valid_i = 1'b0;
    in_data_i = '0;
    repeat (3) @(posedge clk);
    #1;
    rst_n = 1'b1;
    t_reset();
    t_first_values();
    t_restart();
    t_block(0, 0, "half scale");
    t_after_done();
    t_block(1, 0, "most negative");
    t_block(2, 0, "pseudo random");
    t_block(2, 2, "pseudo random gapped");
    t_after_done();
    finish_run();
  end
endmodule